// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the three interrupt sources of a graphics engine into one request line for the host. Two sources are events: a single-cycle pulse when the binning stage finishes its final flush, and a pulse when the render stage completes a frame. Each pulse latches a pending bit that the host acknowledges by writing a one to it. The third source is a level condition, the binner running out of memory. Once raised, that condition keeps its pending bit set through any number of acknowledge writes. It only goes away when the host gives the binner a fresh overflow pool.

The host sees a small register window. A pending-status word is cleared bit by bit by writing ones. Two enable ports both read back the same mask: writing ones to one port turns interrupts on, and writing ones to the other turns them off, so no read-modify-write is needed. Two further words hold the base address and byte size of the overflow pool, and both are driven out to the binner. Writing the size word is the act that supplies the pool, and it clears the out-of-memory condition. At power-up no pool has been supplied, so the out-of-memory condition is present from reset. It becomes the first request the host sees once it enables that interrupt.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the status word, the enable mask, the pool address, the pool size and `irq_out` all read zero.
- R2: A pulse on `ev_render_done` sets status bit 0, and a pulse on `ev_bin_flush_done` sets status bit 1, both at the clock edge that samples the pulse. Such a bit stays set until a status write (address 0) carries a one in that position. Zero bits in that write leave the matching bits unchanged.
- R3: A write to address 1 enables every interrupt whose data bit is one. Zero bits leave the mask unchanged.
- R4: A write to address 2 disables every interrupt whose data bit is one. Zero bits leave the mask unchanged.
- R5: Reads of address 1 and of address 2 both return the current enable mask in bits 2:0.
- R6: `irq_out` is a register. It is high in the cycle after any status bit is set together with its enable bit, and low in the cycle after no such pair exists.
- R7: The out-of-memory condition is present from reset and is raised again by a pulse on `ev_bin_oom`. While it is present, status bit 2 is set on every clock edge, so a status write with a one in bit 2 does not clear it.
- R8: A write to address 4 (pool size) removes the out-of-memory condition, after which a status write with bit 2 set clears status bit 2. If `ev_bin_oom` pulses in the same cycle as that write, the condition stays present.
- R9: When a source pulse and a status write with a one in the same bit arrive in the same cycle, the bit ends up set.
- R10: Status bits 31:3 read as zero, and addresses 5 to 7 read as zero.
- R11: Writes to address 3 and address 4 load the pool address and pool size. These values read back at the same addresses and drive `pool_addr` and `pool_size` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 3 | Register word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_render_done | input | 1 | Frame-render-complete pulse |
| ev_bin_flush_done | input | 1 | Binning-final-flush pulse |
| ev_bin_oom | input | 1 | Binner out-of-memory pulse |
| pool_addr | output | 32 | Overflow pool base address to the binner |
| pool_size | output | 32 | Overflow pool size to the binner |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The pending logic is driven in four ways: by lone event pulses, by acknowledge writes whose data has some zero bits, by a pulse and an acknowledge on the same bit in the same cycle, and by the level out-of-memory source both with and without a pool supply. Together these separate a sticky event latch from a level-fed one, and show which side wins a collision. The mask is driven through both the set port and the clear port, with all-zero data as well as set bits. This catches a port that overwrites the mask instead of merging into it. The request line is sampled both in the cycle just after a change and one cycle later, which pins down the single register stage.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_RENDER = 0;
  localparam int SRC_FLUSH  = 1;
  localparam int SRC_OOM    = 2;

  // one pending bit: a set request outranks an acknowledge
  function automatic logic pend_next(input logic cur, input logic set, input logic ack);
    return set | (cur & ~ack);
  endfunction

  // enable mask after a set-port and a clear-port write
  function automatic logic [NUM_SRC-1:0] mask_next(input logic [NUM_SRC-1:0] cur,
                                                  input logic [NUM_SRC-1:0] on,
                                                  input logic [NUM_SRC-1:0] off);
    return (cur | on) & ~off;
  endfunction
endpackage

// File: rtl/gfx_irq_status.sv
module gfx_irq_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] ack_req,
  output logic [N-1:0] pend
);
  import gfx_irq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= pend_next(pend[i], set_req[i], ack_req[i]);
    end
  end

  // R9: a requested set is always visible after the edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((pend & $past(set_req)) == $past(set_req)));

  // R2: bits with neither set nor acknowledge keep their value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(set_req) & ~$past(ack_req)) ==
              ($past(pend) & ~$past(set_req) & ~$past(ack_req))));
endmodule

// File: rtl/gfx_irq_enable.sv
module gfx_irq_enable #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] on_req,
  input  logic [N-1:0] off_req,
  output logic [N-1:0] mask
);
  import gfx_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_next(mask, on_req, off_req);
  end

  a_r3_on_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (|on_req && !(|off_req)) |=> ((mask & $past(on_req)) == $past(on_req)));

  a_r4_off_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (|off_req) |=> ((mask & $past(off_req)) == '0));
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              size_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oom_ev,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] size_q,
  output logic              oom_cause
);
  import gfx_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      size_q    <= '0;
      oom_cause <= 1'b1;
    end else begin
      if (base_wr) base_q <= wdata;
      if (size_wr) size_q <= wdata;
      oom_cause <= pend_next(oom_cause, oom_ev, size_wr);
    end
  end

  a_r8_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (size_wr && !oom_ev) |=> !oom_cause);

  a_r8_event_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    oom_ev |=> oom_cause);

  a_r11_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (base_q == $past(wdata)));
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_render_done,
  input  logic              ev_bin_flush_done,
  input  logic              ev_bin_oom,
  output logic [DATA_W-1:0] pool_addr,
  output logic [DATA_W-1:0] pool_size,
  output logic              irq_out
);
  import gfx_irq_pkg::*;

  localparam int N = NUM_SRC;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN_ON  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN_OFF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SIZE   = ADDR_W'(4);

  logic         wr_status, wr_on, wr_off, wr_base, wr_size;
  logic [N-1:0] status, mask, set_req, ack_req, on_req, off_req;
  logic         oom_cause, irq_pend;

  assign wr_status = bus_wr && (bus_addr == A_STATUS);
  assign wr_on     = bus_wr && (bus_addr == A_EN_ON);
  assign wr_off    = bus_wr && (bus_addr == A_EN_OFF);
  assign wr_base   = bus_wr && (bus_addr == A_BASE);
  assign wr_size   = bus_wr && (bus_addr == A_SIZE);

  assign ack_req = wr_status ? bus_wdata[N-1:0] : '0;
  assign on_req  = wr_on     ? bus_wdata[N-1:0] : '0;
  assign off_req = wr_off    ? bus_wdata[N-1:0] : '0;

  always_comb begin
    set_req             = '0;
    set_req[SRC_RENDER] = ev_render_done;
    set_req[SRC_FLUSH]  = ev_bin_flush_done;
    set_req[SRC_OOM]    = oom_cause;
  end

  gfx_irq_status #(.N(N)) u_status (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .ack_req(ack_req), .pend(status)
  );

  gfx_irq_enable #(.N(N)) u_enable (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req), .mask(mask)
  );

  gfx_irq_pool #(.DATA_W(DATA_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .base_wr(wr_base), .size_wr(wr_size),
    .wdata(bus_wdata), .oom_ev(ev_bin_oom),
    .base_q(pool_addr), .size_q(pool_size), .oom_cause(oom_cause)
  );

  assign irq_pend = |(status & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= irq_pend;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_STATUS:         bus_rdata = {{(DATA_W-N){1'b0}}, status};
      A_EN_ON, A_EN_OFF: bus_rdata = {{(DATA_W-N){1'b0}}, mask};
      A_BASE:           bus_rdata = pool_addr;
      A_SIZE:           bus_rdata = pool_size;
      default:          bus_rdata = '0;
    endcase
  end

  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> irq_out);

  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |=> !irq_out);

  a_r7_cause_holds_status: assert property (@(posedge clk) disable iff (!rst_n)
    oom_cause |=> status[SRC_OOM]);

  // R1: nothing requested while in reset
  always_ff @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (irq_out == 1'b0);
  end
endmodule

// File: tb/gfx_irq_ctrl_test.sv
module gfx_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_render_done = 1'b0, ev_bin_flush_done = 1'b0, ev_bin_oom = 1'b0;
  logic [31:0] pool_addr, pool_size;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gfx_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_render_done(ev_render_done), .ev_bin_flush_done(ev_bin_flush_done),
    .ev_bin_oom(ev_bin_oom), .pool_addr(pool_addr), .pool_size(pool_size),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, held over one posedge, released at the next negedge
  task automatic cycle_drive(input logic wr, input logic [2:0] a, input logic [31:0] d,
                             input logic [2:0] ev);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ev_render_done = ev[0]; ev_bin_flush_done = ev[1]; ev_bin_oom = ev[2];
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    ev_render_done = 1'b0; ev_bin_flush_done = 1'b0; ev_bin_oom = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cycle_drive(1'b1, a, d, 3'b000);
  endtask

  task automatic pulse(input logic [2:0] ev);
    cycle_drive(1'b0, 3'd0, '0, ev);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 status", v, 32'h0);
    rd(3'd1, v); check("R1 mask", v, 32'h0);
    rd(3'd3, v); check("R1 pool addr", v, 32'h0);
    rd(3'd4, v); check("R1 pool size", v, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    idle();
    rd(3'd0, v); check("R7 oom pending from reset", v, 32'h4);
    check("R6 masked oom no irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_oom_sticky();
    logic [31:0] v;
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R7 ack without pool", v, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd1, v); check("R3 enable oom", v, 32'h4);
    rd(3'd2, v); check("R5 clear port reads mask", v, 32'h4);
    check("R6 irq one cycle later", {31'b0, irq_out}, 32'h0);
    idle();
    check("R6 irq raised", {31'b0, irq_out}, 32'h1);
  endtask

  task automatic t_supply();
    logic [31:0] v;
    wr(3'd3, 32'h8000_1000);
    check("R11 pool_addr out", pool_addr, 32'h8000_1000);
    rd(3'd0, v); check("R8 base write keeps oom", v, 32'h4);
    wr(3'd4, 32'h0002_0000);
    check("R11 pool_size out", pool_size, 32'h0002_0000);
    rd(3'd4, v); check("R11 size readback", v, 32'h0002_0000);
    rd(3'd0, v); check("R8 status still pending", v, 32'h4);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R8 ack after supply", v, 32'h0);
    idle();
    check("R6 irq dropped", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(3'b001);
    rd(3'd0, v); check("R2 render sets bit0", v, 32'h1);
    pulse(3'b010);
    rd(3'd0, v); check("R2 flush sets bit1", v, 32'h3);
    idle();
    rd(3'd0, v); check("R2 bits stay", v, 32'h3);
    wr(3'd0, 32'h2);
    rd(3'd0, v); check("R2 partial ack", v, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R2 full ack", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd1, 32'h3);
    rd(3'd1, v); check("R3 merge on", v, 32'h7);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R3 zero ignored", v, 32'h7);
    wr(3'd2, 32'h4);
    rd(3'd2, v); check("R4 disable oom", v, 32'h3);
    wr(3'd2, 32'h0);
    rd(3'd1, v); check("R4 zero ignored", v, 32'h3);
    pulse(3'b001);
    idle();
    check("R6 render irq", {31'b0, irq_out}, 32'h1);
    wr(3'd2, 32'h1);
    idle();
    check("R6 masked off", {31'b0, irq_out}, 32'h0);
    rd(3'd0, v); check("R4 status kept when masked", v, 32'h1);
    wr(3'd0, 32'h1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pulse(3'b010);
    cycle_drive(1'b1, 3'd0, 32'h2, 3'b010);
    rd(3'd0, v); check("R9 event beats ack", v, 32'h2);
    wr(3'd0, 32'h2);
    rd(3'd0, v); check("R9 later ack clears", v, 32'h0);
    pulse(3'b100);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R7 oom event sticky", v, 32'h4);
    cycle_drive(1'b1, 3'd4, 32'h100, 3'b100);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R8 oom with supply kept", v, 32'h4);
    wr(3'd4, 32'h200);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R8 second supply clears", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFF8);
    rd(3'd0, v); check("R10 upper status zero", v, 32'h0);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); check("R10 unmapped reads zero", v, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_oom_sticky();
    t_supply();
    t_events();
    t_mask();
    t_collision();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule